// File: doc/BRIEF.md
# Bus transfer error responder

This block sits beside a system bus and judges every transaction it sees. At the start of a transfer it checks the access type against the region being addressed. The internal register/RAM region accepts only single beats that are naturally aligned. The local-bus region accepts no bursts. An access that breaks either rule is ended with a one-cycle transfer-error pulse, and the block withholds the normal acknowledge for that transfer.

Legal transfers arm a bus monitor. The monitor loads a programmable cycle count and ends the transfer with a transfer-error pulse if the slave never acknowledges in time. Parity errors take a separate route: they raise a machine-check request. That request is a level output and holds until software clears it.

A sticky cause vector shows software which condition occurred. Each cause bit clears only through a write-one-to-clear strobe.

Top module: `txn_fault_unit`

## Requirements
- R1: After synchronous reset, `terr_o`, `mchk_o`, `ack_o` and all bits of `cause_o` are 0.
- R2: A transfer start to the internal region whose address is not a multiple of the transfer size raises `terr_o` in the cycle after the start and sets cause bit 0. The `size_i` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, and the check uses the low 0, 1, 2 or 3 address bits.
- R3: A burst start to the internal region raises `terr_o` in the cycle after the start and sets cause bit 1.
- R4: A burst start to the local-bus region raises `terr_o` in the cycle after the start and sets cause bit 2.
- R5: The following starts raise no `terr_o`: aligned single beats to the internal region, single beats of any alignment to the local region, and bursts outside both regions.
- R6: If a legal transfer starts with a timeout load of N and is not acknowledged, `terr_o` rises N+2 cycles after the start is driven (the monitor fires one cycle after its count reaches zero), and cause bit 3 is set.
- R7: An acknowledge that arrives at or before the edge where the count is zero stops the monitor, and no `terr_o` follows.
- R8: `ack_o` follows `ack_i` only while a legal transfer is outstanding. It stays 0 for a rejected transfer, after a timeout, and while idle.
- R9: `par_err_i` sets cause bit 4 at the next edge. `mchk_o` follows cause bit 4 and stays high until that bit is cleared.
- R10: Each `clr_i` bit clears the matching cause bit at the next edge. A cause event in the same cycle wins over the clear, and bits not selected are untouched.
- R11: `terr_o` is a single-cycle pulse for each rejected or timed-out transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer-start strobe |
| addr_i | input | ADDR_W | Transfer address |
| size_i | input | 2 | Transfer size code (0:1B,1:2B,2:4B,3:8B) |
| burst_i | input | 1 | Transfer is a burst |
| in_int_i | input | 1 | Address decodes to internal register/RAM region |
| in_loc_i | input | 1 | Address decodes to local-bus region |
| ack_i | input | 1 | Normal acknowledge from the slave |
| par_err_i | input | 1 | Parity error report |
| tmo_load_i | input | TMO_W | Bus-monitor cycle count |
| clr_i | input | 5 | Write-one-to-clear strobes for the cause bits |
| terr_o | output | 1 | Transfer-error acknowledge pulse |
| ack_o | output | 1 | Qualified normal acknowledge |
| mchk_o | output | 1 | Machine-check request level |
| cause_o | output | 5 | Sticky cause: 0 unaligned, 1 internal burst, 2 local burst, 3 timeout, 4 parity |

## Verification
The alignment check is exercised with half, word and doubleword accesses at addresses that are aligned for a smaller size but not for the size used. This separates a correct size decode from one that tests too few or too many address bits. Bursts are sent to each region and to neither region, which shows that each region flag selects its own rule. Monitor timing is tested three ways: with no acknowledge, with an acknowledge at the last legal edge, and with an early acknowledge. These three cases pin down the exact firing cycle. Parity and clear strobes are applied both separately and in the same cycle, which confirms stickiness, set priority and per-bit clearing.

// File: rtl/txn_fault_pkg.sv
package txn_fault_pkg;

    localparam int CAUSE_W = 5;

    typedef enum logic [2:0] {
        C_UNALIGN = 3'd0,
        C_IBURST  = 3'd1,
        C_LBURST  = 3'd2,
        C_TMO     = 3'd3,
        C_PAR     = 3'd4
    } cause_idx_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic lburst;
        logic iburst;
        logic unalign;
    } reject_t;

    // Low-address mask that must be zero for a naturally aligned access.
    function automatic logic [2:0] align_mask(xfer_size_e sz);
        case (sz)
            SZ_BYTE: return 3'b000;
            SZ_HALF: return 3'b001;
            SZ_WORD: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/fault_chk.sv
module fault_chk
    import txn_fault_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              burst_i,
    input  logic              in_int_i,
    input  logic              in_loc_i,
    output reject_t           rej_now_o,
    output logic              rej_any_o,
    output logic              rej_q_o
);

    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'(3'b111);

    logic [ADDR_W-1:0] mask;
    reject_t           rej;

    always_comb begin
        mask        = ADDR_W'(align_mask(xfer_size_e'(size_i))) & LOW_ONES;
        rej.unalign = start_i && in_int_i && ((addr_i & mask) != '0);
        rej.iburst  = start_i && in_int_i && burst_i;
        rej.lburst  = start_i && in_loc_i && burst_i;
    end

    assign rej_now_o = rej;
    assign rej_any_o = |rej;

    always_ff @(posedge clk) begin
        if (rst) rej_q_o <= 1'b0;
        else     rej_q_o <= |rej;
    end

    assert_rej_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        rej_q_o |-> $past(start_i));

    assert_burst_int_R3: assert property (@(posedge clk) disable iff (rst)
        (start_i && in_int_i && burst_i) |=> rej_q_o);

endmodule

// File: rtl/bus_mon.sv
module bus_mon #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             ack_i,
    input  logic [TMO_W-1:0] load_i,
    output logic             busy_o,
    output logic             fire_o,
    output logic             tmo_q_o
);

    logic [TMO_W-1:0] cnt;

    assign fire_o = busy_o && !arm_i && !ack_i && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            cnt     <= '0;
            tmo_q_o <= 1'b0;
        end else begin
            tmo_q_o <= fire_o;
            if (arm_i) begin
                busy_o <= 1'b1;
                cnt    <= load_i;
            end else if (busy_o) begin
                if (ack_i || cnt == '0) busy_o <= 1'b0;
                else                    cnt    <= cnt - 1'b1;
            end
        end
    end

    assert_tmo_needs_busy_R6: assert property (@(posedge clk) disable iff (rst)
        tmo_q_o |-> ($past(busy_o) && !$past(ack_i)));

    assert_ack_stops_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ack_i && !arm_i) |=> (!busy_o && !tmo_q_o));

endmodule

// File: rtl/cause_reg.sv
module cause_reg
    import txn_fault_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic [CAUSE_W-1:0] clr_i,
    output logic [CAUSE_W-1:0] cause_o
);

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           cause_o[i] <= 1'b0;
            else if (set_i[i]) cause_o[i] <= 1'b1;
            else if (clr_i[i]) cause_o[i] <= 1'b0;
        end

        assert_fall_needs_clr_R10: assert property (@(posedge clk) disable iff (rst)
            $fell(cause_o[i]) |-> $past(clr_i[i]));

        assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> cause_o[i]);
    end

endmodule

// File: rtl/txn_fault_unit.sv
module txn_fault_unit
    import txn_fault_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              burst_i,
    input  logic              in_int_i,
    input  logic              in_loc_i,
    input  logic              ack_i,
    input  logic              par_err_i,
    input  logic [TMO_W-1:0]  tmo_load_i,
    input  logic [4:0]        clr_i,
    output logic              terr_o,
    output logic              ack_o,
    output logic              mchk_o,
    output logic [4:0]        cause_o
);

    reject_t            rej_now;
    logic               rej_any;
    logic               rej_q;
    logic               busy;
    logic               fire;
    logic               tmo_q;
    logic [CAUSE_W-1:0] set_vec;

    fault_chk #(.ADDR_W(ADDR_W)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .addr_i   (addr_i),
        .size_i   (size_i),
        .burst_i  (burst_i),
        .in_int_i (in_int_i),
        .in_loc_i (in_loc_i),
        .rej_now_o(rej_now),
        .rej_any_o(rej_any),
        .rej_q_o  (rej_q)
    );

    bus_mon #(.TMO_W(TMO_W)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (start_i && !rej_any),
        .ack_i  (ack_i),
        .load_i (tmo_load_i),
        .busy_o (busy),
        .fire_o (fire),
        .tmo_q_o(tmo_q)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[C_UNALIGN] = rej_now.unalign;
        set_vec[C_IBURST]  = rej_now.iburst;
        set_vec[C_LBURST]  = rej_now.lburst;
        set_vec[C_TMO]     = fire;
        set_vec[C_PAR]     = par_err_i;
    end

    cause_reg u_cause (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_i),
        .cause_o(cause_o)
    );

    assign terr_o = rej_q | tmo_q;
    assign ack_o  = ack_i & busy;
    assign mchk_o = cause_o[C_PAR];

    assert_no_ack_on_terr_R8: assert property (@(posedge clk) disable iff (rst)
        terr_o |-> !ack_o);

    assert_terr_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
        terr_o |-> (cause_o[3:0] != 4'b0000));

    assert_parity_mchk_R9: assert property (@(posedge clk) disable iff (rst)
        par_err_i |=> mchk_o);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!terr_o && !mchk_o && cause_o == '0));

endmodule

// File: tb/test_txn_fault_unit.sv
module test_txn_fault_unit;

    localparam int ADDR_W = 32;
    localparam int TMO_W  = 16;
    localparam int N      = 5;

    logic              clk = 0;
    logic              rst = 1;
    logic              start_i = 0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [1:0]        size_i = '0;
    logic              burst_i = 0;
    logic              in_int_i = 0;
    logic              in_loc_i = 0;
    logic              ack_i = 0;
    logic              par_err_i = 0;
    logic [TMO_W-1:0]  tmo_load_i = TMO_W'(N);
    logic [4:0]        clr_i = '0;
    logic              terr_o, ack_o, mchk_o;
    logic [4:0]        cause_o;

    txn_fault_unit #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) i_txn_fault_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
        .size_i(size_i), .burst_i(burst_i), .in_int_i(in_int_i),
        .in_loc_i(in_loc_i), .ack_i(ack_i), .par_err_i(par_err_i),
        .tmo_load_i(tmo_load_i), .clr_i(clr_i), .terr_o(terr_o),
        .ack_o(ack_o), .mchk_o(mchk_o), .cause_o(cause_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        int         cyc;
        logic       terr;
        logic [4:0] cause;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    logic [4:0] exp_cause = '0;
    bit         done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(int c, logic t, string tag);
        exp_t e;
        e.cyc = c; e.terr = t; e.cause = exp_cause; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items as the design produces them.
    always @(negedge clk) begin
        bit   terr_expected;
        exp_t e;
        terr_expected = 0;
        if (!rst) begin
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                e = sb.pop_front();
                checks++;
                if (e.terr) terr_expected = 1;
                if (terr_o !== e.terr || cause_o !== e.cause || mchk_o !== e.cause[4]) begin
                    fails++;
                    $display("FAIL %s @%0d: actual terr=%b cause=%b mchk=%b expected terr=%b cause=%b mchk=%b",
                             e.tag, cyc, terr_o, cause_o, mchk_o, e.terr, e.cause, e.cause[4]);
                end
            end
            if (terr_o === 1'b1 && !terr_expected) begin
                checks++; fails++;
                $display("FAIL R5/R11 unexpected pulse @%0d: actual terr=1 expected terr=0", cyc);
            end
        end
    end

    // ack_after: edge index of the acknowledge after the start edge, <=0 for none.
    task automatic run_txn(string tag, logic [ADDR_W-1:0] a, logic [1:0] sz,
                           logic b, logic ii, logic ll, int ack_after);
        int         c;
        logic [2:0] m;
        logic [4:0] flags;
        logic       ill;
        @(posedge clk); #1;
        c = cyc;
        start_i = 1; addr_i = a; size_i = sz; burst_i = b; in_int_i = ii; in_loc_i = ll;
        m = (sz == 2'd0) ? 3'b000 : (sz == 2'd1) ? 3'b001 : (sz == 2'd2) ? 3'b011 : 3'b111;
        flags = '0;
        flags[0] = ii && ((a[2:0] & m) != 3'b000);
        flags[1] = ii && b;
        flags[2] = ll && b;
        ill = |flags;
        exp_cause |= flags;
        push(c + 1, ill, tag);
        if (ill) push(c + 2, 1'b0, {tag, " R11 pulse width"});
        @(posedge clk); #1;
        start_i = 0; burst_i = 0; in_int_i = 0; in_loc_i = 0;
        if (ack_after > 0) begin
            repeat (ack_after - 1) @(posedge clk);
            #1;
            ack_i = 1;
            #1 check_bit({tag, " R8 ack_o"}, ack_o, !ill);
            @(posedge clk); #1;
            ack_i = 0;
        end
        if (!ill && (ack_after <= 0 || ack_after > N + 1)) begin
            exp_cause[3] = 1'b1;
            push(c + N + 2, 1'b1, {tag, " R6 timeout"});
            push(c + N + 3, 1'b0, {tag, " R11 timeout width"});
        end
        while (cyc <= c + N + 4) @(posedge clk);
        #1;
    endtask

    task automatic clear(logic [4:0] mask, logic par);
        int c;
        @(posedge clk); #1;
        c = cyc;
        clr_i = mask; par_err_i = par;
        exp_cause &= ~mask;
        if (par) exp_cause[4] = 1'b1;
        push(c + 1, 1'b0, par ? "R10 set wins over clear" : "R10 clear");
        @(posedge clk); #1;
        clr_i = '0; par_err_i = 0;
    endtask

    task automatic parity_pulse();
        int c;
        @(posedge clk); #1;
        c = cyc;
        par_err_i = 1;
        exp_cause[4] = 1'b1;
        push(c + 1, 1'b0, "R9 parity sets mchk");
        @(posedge clk); #1;
        par_err_i = 0;
        push(c + 10, 1'b0, "R9 mchk held");
        repeat (10) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        push(cyc, 1'b0, "R1 reset state");
        #1 check_bit("R1 ack_o after reset", ack_o, 1'b0);
        @(posedge clk); #1;

        // R2 unaligned internal: half odd, word at 2, dword at 4
        run_txn("R2 half@0x101", 32'h101, 2'd1, 0, 1, 0, 1);
        run_txn("R2 word@0x102", 32'h102, 2'd2, 0, 1, 0, 0);
        run_txn("R2 dword@0x104", 32'h104, 2'd3, 0, 1, 0, 0);
        clear(5'h1F, 0);
        // R3 / R4 bursts
        run_txn("R3 internal burst", 32'h200, 2'd3, 1, 1, 0, 0);
        run_txn("R4 local burst", 32'h300, 2'd3, 1, 0, 1, 0);
        clear(5'h1F, 0);
        // R5 legal accesses, R7 ack stops monitor
        run_txn("R5 byte odd internal", 32'h7, 2'd0, 0, 1, 0, 2);
        run_txn("R5 dword aligned internal", 32'h18, 2'd3, 0, 1, 0, 1);
        run_txn("R5 single odd local", 32'h405, 2'd2, 0, 0, 1, 3);
        run_txn("R5 burst plain memory", 32'h500, 2'd3, 1, 0, 0, 4);
        run_txn("R7 ack at last edge", 32'h20, 2'd2, 0, 1, 0, N + 1);
        // R6 timeout
        run_txn("R6 no ack", 32'h40, 2'd2, 0, 1, 0, 0);
        // R8 idle ack masked
        ack_i = 1;
        #1 check_bit("R8 idle ack_o", ack_o, 1'b0);
        @(posedge clk); #1 ack_i = 0;
        clear(5'b01000, 0);
        // R9 parity, R10 clear and priority
        parity_pulse();
        run_txn("R4 local burst with parity set", 32'h600, 2'd0, 1, 0, 1, 0);
        clear(5'b00100, 0);
        clear(5'b10000, 1);
        clear(5'b10000, 0);
        push(cyc + 3, 1'b0, "R9 mchk dropped");
        repeat (5) @(posedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1-all: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule